// File: doc/BRIEF.md
# Configurable Five-Master Bus Arbiter

This block decides which of five masters owns a shared system bus. The masters are, by index, the processor (0), the DMA engine (1), the bridge port (2), the USB controller (3) and the display controller (4). A master raises its request line. The arbiter answers with a one-hot grant and an ownership flag. The owner keeps the bus until it pulses the handover/done input. That pulse is an arbitration point, and so is every cycle in which nobody owns the bus.

A single configuration word, written and read through a simple register port, controls the scheduling. With bit 0 set, all masters rank equally and are served in rotation. With bit 0 clear, each master carries its own programmable rank, and masters of equal rank are served in rotation among themselves. Two independent arbiters are made by instantiating the block twice. Each instance has its own word and the same reset value, set by the `CFG_RESET` parameter.

Top module: `arb5_bus_arbiter`

## Requirements
- R1: During and right after reset, `cfg_rdata_o` reads 0x0000_0145, `owned_o` is 0 and `gnt_o` is 5'b00001 (parked on the processor). The rotation pointer starts at master 0.
- R2: When `cfg_we_i` is high at a clock edge, `cfg_wdata_i` is stored. `cfg_rdata_o` shows it from the following cycle onward, with all 32 bits kept.
- R3: `gnt_o` always has exactly one bit set. Whenever no master owns the bus (`owned_o` = 0), the set bit is bit 0.
- R4: While `owned_o` is 1 and `done_i` is low, the grant does not change at the next edge. This holds whatever the requests or register writes.
- R5: In rotation mode the winner is the first requesting master found by scanning upward from the pointer, wrapping from 4 to 0. After reset, precedence is therefore 0,1,2,3,4.
- R6: The pointer moves to (owner+1) mod 5 only at an edge where the owner pulses `done_i`. A `done_i` with no owner has no effect.
- R7: In priority mode, master m's rank is the 3-bit field cfg[3m+3:3m+1]. Rank 5 is highest and rank 1 is lowest. A field value of 0, 6 or 7 counts as rank 1. The requesting master with the highest rank wins.
- R8: Among requesting masters that share the highest rank, the winner is chosen by the rotation scan of R5.
- R9: A register write never revokes a current grant. Each arbitration uses the word held in the register during that cycle, so a write takes effect at the first arbitration point after its edge.
- R10: A request seen in an unowned cycle is granted at the next edge. A `done_i` pulse with requests pending hands the bus over at that same edge, with no idle cycle. A `done_i` pulse with no requests parks the grant.
- R11: Bit 0 of the word selects the mode: 1 gives rotation with the rank fields ignored, and 0 gives priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Bus requests, bit m from master m |
| done_i | input | 1 | Owner releases the bus (handover pulse) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration word read-back |
| gnt_o | output | 5 | One-hot grant |
| owned_o | output | 1 | Grant is an active ownership, not parking |

## Verification
The assertions watch several properties on every cycle: that the grant is one-hot and parks on the processor when unowned, that an owned grant holds until a handover, that the pointer moves only on a release, that a new grant always goes to a master that was requesting, and that a handover with pending requests leaves no gap. Which master wins at each arbitration point depends on the rank fields, tie rotation and the exact timing of configuration writes. Only the bench's cycle-by-cycle reference model can show that, across directed scenarios and a long random mix of requests, releases and writes.

// File: rtl/arb5_pkg.sv
package arb5_pkg;
  localparam int NUM_M   = 5;
  localparam int PRIO_W  = 3;
  localparam int LVL_MAX = 5;
  localparam int CFG_W   = 32;
  localparam int IDX_W   = $clog2(NUM_M);

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [PRIO_W-1:0] lvl_t;
  typedef logic [CFG_W-1:0]  cfg_t;

  // raw rank field of master m
  function automatic lvl_t rank_field(cfg_t cfg, int m);
    return cfg[1 + m*PRIO_W +: PRIO_W];
  endfunction

  // effective rank: all equal in rotation mode, out-of-range folds to lowest
  function automatic lvl_t eff_level(lvl_t raw, logic rot_mode);
    if (rot_mode) return lvl_t'(1);
    if (raw == '0 || raw > lvl_t'(LVL_MAX)) return lvl_t'(1);
    return raw;
  endfunction

  function automatic idx_t wrap_inc(idx_t i);
    return (i == idx_t'(NUM_M-1)) ? '0 : i + idx_t'(1);
  endfunction
endpackage

// File: rtl/arb5_cfg_reg.sv
module arb5_cfg_reg
  import arb5_pkg::*;
#(
  parameter cfg_t RST_VAL = 32'h0000_0145
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  cfg_t wdata_i,
  output cfg_t q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (we_i)  q_o <= wdata_i;
  end
endmodule

// File: rtl/arb5_pick.sv
module arb5_pick
  import arb5_pkg::*;
(
  input  logic [NUM_M-1:0] req_i,
  input  lvl_t [NUM_M-1:0] lvl_i,
  input  idx_t             start_i,
  output idx_t             win_o,
  output logic             any_o
);
  lvl_t best;
  always_comb begin
    best  = '0;
    win_o = '0;
    any_o = |req_i;
    // scanning in rotation order with strict compare keeps the first tie
    for (int k = 0; k < NUM_M; k++) begin
      int idx;
      idx = (int'(start_i) + k) % NUM_M;
      if (req_i[idx] && lvl_i[idx] > best) begin
        best  = lvl_i[idx];
        win_o = idx_t'(idx);
      end
    end
  end
endmodule

// File: rtl/arb5_bus_arbiter.sv
module arb5_bus_arbiter
  import arb5_pkg::*;
#(
  parameter logic [31:0] CFG_RESET = 32'h0000_0145
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  req_i,
  input  logic        done_i,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic [4:0]  gnt_o,
  output logic        owned_o
);
  cfg_t cfg_q;
  logic owned_q;
  idx_t owner_q, ptr_q;

  arb5_cfg_reg #(.RST_VAL(CFG_RESET)) cfg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .q_o    (cfg_q)
  );

  // named events for the checker
  logic release_ev, arb_pt;
  idx_t sel_ptr;
  assign release_ev = owned_q & done_i;
  assign arb_pt     = ~owned_q | done_i;
  assign sel_ptr    = release_ev ? wrap_inc(owner_q) : ptr_q;

  lvl_t [NUM_M-1:0] lvl_w;
  for (genvar g = 0; g < NUM_M; g++) begin : g_lvl
    assign lvl_w[g] = eff_level(rank_field(cfg_q, g), cfg_q[0]);
  end

  idx_t win;
  logic any_req;
  arb5_pick pick_i (
    .req_i  (req_i),
    .lvl_i  (lvl_w),
    .start_i(sel_ptr),
    .win_o  (win),
    .any_o  (any_req)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      owned_q <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      ptr_q <= sel_ptr;
      if (arb_pt) begin
        owned_q <= any_req;
        owner_q <= any_req ? win : '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : g_gnt
    assign gnt_o[g] = (owner_q == idx_t'(g));
  end

  assign owned_o     = owned_q;
  assign cfg_rdata_o = cfg_q;
endmodule

// File: rtl/arb5_bus_arbiter_chk.sv
module arb5_bus_arbiter_chk
  import arb5_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  req_i,
  input logic        done_i,
  input logic        cfg_we_i,
  input logic [31:0] cfg_wdata_i,
  input logic [31:0] cfg_rdata_i,
  input logic [4:0]  gnt_i,
  input logic        owned_i,
  input logic        arb_pt_i,
  input idx_t        ptr_i
);
  a_r3_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_i) == 1);

  a_r3_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !owned_i |-> gnt_i == 5'b00001);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owned_i && !done_i |=> owned_i && $stable(gnt_i));

  a_r4_no_arb_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arb_pt_i |=> $stable(gnt_i));

  a_r6_ptr_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(owned_i && done_i) |=> $stable(ptr_i));

  a_r2_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_i == $past(cfg_wdata_i));

  a_r10_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owned_i && done_i && (req_i != 5'b0) |=> owned_i);

  a_r10_idle_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !owned_i && (req_i != 5'b0) |=> owned_i);

  a_r10_winner_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_pt_i && (req_i != 5'b0) |=> (gnt_i & $past(req_i)) != 5'b0);
endmodule

bind arb5_bus_arbiter arb5_bus_arbiter_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .done_i     (done_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_i(cfg_rdata_o),
  .gnt_i      (gnt_o),
  .owned_i    (owned_o),
  .arb_pt_i   (arb_pt),
  .ptr_i      (ptr_q)
);

// File: tb/arb5_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module arb5_bus_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  req;
  logic        done;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [4:0]  gnt;
  logic        owned;

  int tests = 0;
  int fails = 0;

  // reference model state
  logic [31:0] m_cfg;
  int          m_owner, m_ptr;
  bit          m_owned;

  always #2 clk = ~clk;

  arb5_bus_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .gnt_o(gnt), .owned_o(owned)
  );

  function automatic int ref_rank(logic [31:0] c, int m);
    int v;
    if (c[0]) return 1;
    v = int'((c >> (1 + 3*m)) & 32'd7);
    if (v < 1 || v > 5) v = 1;
    return v;
  endfunction

  // two passes: find the top rank, then walk from the pointer
  function automatic int ref_pick(logic [4:0] r, int start, logic [31:0] c);
    int top = 0;
    for (int m = 0; m < 5; m++)
      if (r[m] && ref_rank(c, m) > top) top = ref_rank(c, m);
    for (int k = 0; k < 5; k++) begin
      int idx = (start + k) % 5;
      if (r[idx] && ref_rank(c, idx) == top) return idx;
    end
    return 0;
  endfunction

  task automatic model_edge();
    int np;
    np = (m_owned && done) ? (m_owner + 1) % 5 : m_ptr;
    if (!m_owned || done) begin
      if (req != 5'b0) begin
        m_owner = ref_pick(req, np, m_cfg);
        m_owned = 1;
      end else begin
        m_owner = 0;
        m_owned = 0;
      end
    end
    m_ptr = np;
    if (cfg_we) m_cfg = cfg_wdata;
  endtask

  task automatic compare(string tag);
    logic [4:0] eg;
    eg = 5'(1 << m_owner);
    tests++;
    if (gnt !== eg || owned !== m_owned || cfg_rdata !== m_cfg) begin
      fails++;
      $display("FAIL %s: gnt=%b owned=%b cfg=%h, expected gnt=%b owned=%b cfg=%h",
               tag, gnt, owned, cfg_rdata, eg, m_owned, m_cfg);
    end
  endtask

  // drive at negedge, model at the edge, compare at the next negedge
  task automatic cyc(logic [4:0] r, logic d, logic we, logic [31:0] wd, string tag);
    req = r; done = d; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [31:0] PRIO_CFG = 32'h0000_16B2; // ranks m0=1 m1=3 m2=5 m3=5 m4=0

  initial begin
    rst_n = 1'b0; req = '0; done = 0; cfg_we = 0; cfg_wdata = '0;
    m_cfg = 32'h0000_0145; m_owner = 0; m_ptr = 0; m_owned = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    tests++;
    if (cfg_rdata !== 32'h0000_0145 || gnt !== 5'b00001) begin
      fails++;
      $display("FAIL R1: cfg=%h gnt=%b, expected cfg=00000145 gnt=00001", cfg_rdata, gnt);
    end
    rst_n = 1'b1;

    cyc(5'b11111, 0, 0, '0, "R5 first grant to processor");
    for (int i = 0; i < 6; i++) cyc(5'b11111, 1, 0, '0, "R6 rotation on release");
    for (int i = 0; i < 4; i++) cyc(5'b11110, 0, 0, '0, "R4 grant held");
    cyc(5'b00000, 1, 0, '0, "R10 release with no request parks");
    cyc(5'b00000, 1, 0, '0, "R6 done without owner ignored");
    cyc(5'b00000, 1, 0, '0, "R6 done without owner ignored");
    cyc(5'b10100, 0, 0, '0, "R5 scan from pointer");
    cyc(5'b01000, 1, 0, '0, "R10 handover without gap");
    cyc(5'b11111, 0, 1, PRIO_CFG, "R9 write does not revoke");
    cyc(5'b11111, 0, 0, '0, "R9 write does not revoke");
    for (int i = 0; i < 4; i++) cyc(5'b11111, 1, 0, '0, "R8 equal top ranks rotate");
    for (int i = 0; i < 2; i++) cyc(5'b10011, 1, 0, '0, "R7 higher rank wins");
    for (int i = 0; i < 4; i++) cyc(5'b10001, 1, 0, '0, "R7 rank 0 counts as lowest");
    cyc(5'b10001, 1, 1, PRIO_CFG | 32'h0000_C000, "R7 rank 6 write");
    for (int i = 0; i < 4; i++) cyc(5'b10001, 1, 0, '0, "R7 rank 6 counts as lowest");
    cyc(5'b00000, 1, 1, PRIO_CFG | 32'h1, "R11 mode bit set");
    for (int i = 0; i < 6; i++) cyc(5'b11111, 1, 0, '0, "R11 rotation ignores ranks");
    cyc(5'b00000, 1, 1, 32'hDEAD_BEEF, "R2 full-word write");
    cyc(5'b00100, 0, 0, '0, "R2 read-back kept");
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  r  = 5'($urandom % 32);
      logic        d  = ($urandom % 4) == 0;
      logic        w  = ($urandom % 16) == 0;
      logic [31:0] wd = $urandom;
      cyc(r, d, w, wd, "R3 random mix");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule